// File: doc/BRIEF.md
# Linked-list DMA descriptor engine

This block is the front end of a DMA channel. It turns a chain of buffer descriptors in memory into a sequence of burst requests. Each request is an address and a byte length, and it goes to a bus master that lies outside the block. A descriptor is three 32-bit words in memory: a link word, a buffer base address and a buffer size. Descriptor *i* of a list therefore sits 12·*i* bytes above the list base. The link word has three parts: the byte offset of the next descriptor, a flag that says a further descriptor follows, and a flag that says that descriptor's size word is to be loaded.

Software sets up the first descriptor through a small register port (list base, link, base, size) and then writes the control register. With only the run bit set, the engine moves the single buffer held in the base and size registers. With the run and list bits both set, it transfers the first buffer, then reads the next descriptor, then transfers that buffer, and so on until it finishes a buffer whose link word has the continue flag clear. It checks each buffer before issuing it. A misaligned buffer stops the engine with an error. Writing zero to the control register aborts the engine or clears a finished state.

The state machine has eight states: IDLE, CHECK, XFER, FETCH_LINK, FETCH_BASE, FETCH_SIZE, DONE and ERROR. Its transitions are:
- A start from IDLE, DONE or ERROR moves to CHECK.
- CHECK moves to XFER when the buffer passes its checks, and to ERROR when it fails them.
- When the transfer reports done, XFER moves to DONE after the last buffer, and to FETCH_LINK otherwise.
- FETCH_LINK moves to FETCH_BASE when its word is returned.
- When its word is returned, FETCH_BASE moves to FETCH_SIZE if the size is to be loaded, and to CHECK otherwise.
- FETCH_SIZE moves to CHECK when its word is returned.
- A stop moves any state to IDLE.

Top module: `lldma_engine`

## Requirements
- R1: After reset the engine is idle. busy, done, error, rd_req and xfer_req are all low.
- R2: Writing the control register (address 0) with bit 0 set and bit 1 clear starts single mode. The engine makes exactly one request, with xfer_addr equal to the base register (address 3) and xfer_len equal to the size register (address 4). It reads no descriptor words and ignores the link register. It then raises done.
- R3: Writing control bits 0 and 1 both set starts list mode. The first request uses the preloaded base and size registers. The link register is address 2 and the list base register is address 1. A link word holds the byte offset of the next descriptor in bits 29:0, the continue flag in bit 31 and the load-size flag in bit 30. When bit 31 is set, the engine reads the next descriptor from list base + offset, taking the link word at +0, the base at +4 and the size at +8.
- R4: When the load-size flag of the current link word is clear, the engine skips the size word and reuses the previous length for the next buffer.
- R5: The chain ends after the buffer whose link word has bit 31 clear. The engine then shows done high and busy low.
- R6: xfer_req stays high with a stable address and length until xfer_done. The next descriptor is read only after xfer_done.
- R7: A buffer whose base is not a multiple of 4 is never requested. This applies to a preloaded base, a fetched base and single mode alike. The engine raises error and stops.
- R8: In list mode, a buffer that is not the last must have a size that is a multiple of 2^BLK_LG2 bytes, otherwise the engine raises error. The last buffer, and the buffer in single mode, may have any size.
- R9: Writing 0 to the control register returns the engine to IDLE from any state. One cycle later busy, done, error, rd_req and xfer_req are low.
- R10: rd_req stays high with a stable rd_addr until rd_valid. rd_req and xfer_req are never high together.
- R11: Writes to the list base, link, base or size register while busy is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control, 1 list base, 2 link, 3 base, 4 size |
| cfg_wdata | input | 32 | Register write data |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Byte address of the descriptor word |
| rd_valid | input | 1 | Read data valid, one-cycle pulse |
| rd_data | input | 32 | Descriptor word |
| xfer_req | output | 1 | Burst request to the bus master |
| xfer_addr | output | ADDR_W | Burst start address |
| xfer_len | output | 32 | Burst length in bytes |
| xfer_done | input | 1 | Burst complete, one-cycle pulse |
| busy | output | 1 | Engine is working through a buffer or descriptor |
| done | output | 1 | Last buffer finished |
| error | output | 1 | Alignment fault stopped the engine |

## Verification
The bench builds the engine with BLK_LG2 = 4. The 16-byte block rule is then small enough for short descriptor lists to carry both legal sizes (32, 48, 64) and an illegal size (20) on a buffer that is not the last. A final buffer of 7 bytes shows that the size rule is waived for the last buffer. ADDR_W stays at 32. Every descriptor list fits inside a 64-word memory model, placed at list bases 0x40 and 0x80. Link offsets of 12 and 24 exercise the descriptor address arithmetic with real strides.

// File: rtl/lldma_pkg.sv
`timescale 1ns/1ps
package lldma_pkg;
    localparam int WORD_W        = 32;
    localparam int LNK_CONT_BIT  = 31;
    localparam int LNK_SIZE_BIT  = 30;
    localparam int LNK_OFF_W     = 30;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_LBASE = 3'd1;
    localparam logic [2:0] REG_LINK  = 3'd2;
    localparam logic [2:0] REG_BASE  = 3'd3;
    localparam logic [2:0] REG_SIZE  = 3'd4;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_LIST_BIT = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_XFER,
        ST_FETCH_LINK,
        ST_FETCH_BASE,
        ST_FETCH_SIZE,
        ST_DONE,
        ST_ERROR
    } lldma_state_e;
endpackage

// File: rtl/lldma_cfg_regs.sv
`timescale 1ns/1ps
module lldma_cfg_regs
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_addr_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              open_i,
    input  logic              ld_link_i,
    input  logic              ld_base_i,
    input  logic              ld_size_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] list_base_o,
    output logic [WORD_W-1:0] link_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [WORD_W-1:0] size_o,
    output logic              start_o,
    output logic              start_list_o,
    output logic              stop_o
);
    logic ctrl_wr;

    assign ctrl_wr      = cfg_we_i && (cfg_addr_i == REG_CTRL);
    assign stop_o       = ctrl_wr && (cfg_wdata_i == '0);
    assign start_o      = ctrl_wr && cfg_wdata_i[CTRL_RUN_BIT];
    assign start_list_o = cfg_wdata_i[CTRL_LIST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_base_o <= '0;
            link_o      <= '0;
            base_o      <= '0;
            size_o      <= '0;
        end else begin
            if (ld_link_i) link_o <= rd_data_i;
            if (ld_base_i) base_o <= rd_data_i[ADDR_W-1:0];
            if (ld_size_i) size_o <= rd_data_i;
            if (cfg_we_i && open_i) begin
                unique case (cfg_addr_i)
                    REG_LBASE: list_base_o <= cfg_wdata_i[ADDR_W-1:0];
                    REG_LINK:  link_o      <= cfg_wdata_i;
                    REG_BASE:  base_o      <= cfg_wdata_i[ADDR_W-1:0];
                    REG_SIZE:  size_o      <= cfg_wdata_i;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lldma_buf_check.sv
`timescale 1ns/1ps
module lldma_buf_check
    import lldma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_LG2 = 5
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [WORD_W-1:0] len_i,
    input  logic              last_i,
    output logic              addr_ok_o,
    output logic              len_ok_o
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(3);
    localparam logic [WORD_W-1:0] BLK_MASK  = WORD_W'((64'd1 << BLK_LG2) - 64'd1);

    assign addr_ok_o = ((base_i & WORD_MASK) == '0);
    assign len_ok_o  = last_i || ((len_i & BLK_MASK) == '0);
endmodule

// File: rtl/lldma_fsm.sv
`timescale 1ns/1ps
module lldma_fsm
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_list_i,
    input  logic              stop_i,
    input  logic [WORD_W-1:0] link_i,
    input  logic [ADDR_W-1:0] list_base_i,
    input  logic              addr_ok_i,
    input  logic              len_ok_i,
    input  logic              xfer_done_i,
    input  logic              rd_valid_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              xfer_req_o,
    output logic              last_o,
    output logic              open_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              ld_link_o,
    output logic              ld_base_o,
    output logic              ld_size_o
);
    lldma_state_e      state_q, state_nx;
    logic              ll_mode_q;
    logic              upd_size_q;
    logic [ADDR_W-1:0] desc_ptr_q;
    logic              at_rest;

    assign at_rest = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERROR);
    assign last_o  = !ll_mode_q || !link_i[LNK_CONT_BIT];

    // state register and the per-chain bookkeeping it carries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ll_mode_q  <= 1'b0;
            upd_size_q <= 1'b0;
            desc_ptr_q <= '0;
        end else begin
            state_q <= state_nx;
            if (at_rest && start_i && !stop_i)
                ll_mode_q <= start_list_i;
            if ((state_q == ST_XFER) && xfer_done_i && !last_o) begin
                desc_ptr_q <= list_base_i + ADDR_W'(link_i[LNK_OFF_W-1:0]);
                upd_size_q <= link_i[LNK_SIZE_BIT];
            end
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERROR: begin
                if (stop_i)       state_nx = ST_IDLE;
                else if (start_i) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (stop_i)                       state_nx = ST_IDLE;
                else if (!addr_ok_i || !len_ok_i) state_nx = ST_ERROR;
                else                              state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (stop_i)           state_nx = ST_IDLE;
                else if (xfer_done_i) state_nx = last_o ? ST_DONE : ST_FETCH_LINK;
            end
            ST_FETCH_LINK: begin
                if (stop_i)          state_nx = ST_IDLE;
                else if (rd_valid_i) state_nx = ST_FETCH_BASE;
            end
            ST_FETCH_BASE: begin
                if (stop_i)          state_nx = ST_IDLE;
                else if (rd_valid_i) state_nx = upd_size_q ? ST_FETCH_SIZE : ST_CHECK;
            end
            ST_FETCH_SIZE: begin
                if (stop_i)          state_nx = ST_IDLE;
                else if (rd_valid_i) state_nx = ST_CHECK;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req_o   = 1'b0;
        rd_addr_o  = desc_ptr_q;
        xfer_req_o = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        err_o      = 1'b0;
        open_o     = 1'b0;
        ld_link_o  = 1'b0;
        ld_base_o  = 1'b0;
        ld_size_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                open_o = 1'b1;
            end
            ST_DONE: begin
                busy_o = 1'b0;
                open_o = 1'b1;
                done_o = 1'b1;
            end
            ST_ERROR: begin
                busy_o = 1'b0;
                open_o = 1'b1;
                err_o  = 1'b1;
            end
            ST_CHECK: ;
            ST_XFER: xfer_req_o = 1'b1;
            ST_FETCH_LINK: begin
                rd_req_o  = 1'b1;
                ld_link_o = rd_valid_i;
            end
            ST_FETCH_BASE: begin
                rd_req_o  = 1'b1;
                rd_addr_o = desc_ptr_q + ADDR_W'(4);
                ld_base_o = rd_valid_i;
            end
            ST_FETCH_SIZE: begin
                rd_req_o  = 1'b1;
                rd_addr_o = desc_ptr_q + ADDR_W'(8);
                ld_size_o = rd_valid_i;
            end
            default: busy_o = 1'b0;
        endcase
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i && !stop_i |=> rd_req_o && $stable(rd_addr_o));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && xfer_req_o));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !busy_o && !done_o && !err_o && !rd_req_o && !xfer_req_o);

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o) && !(busy_o && (done_o || err_o)));
endmodule

// File: rtl/lldma_engine.sv
`timescale 1ns/1ps
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_LG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [31:0]       xfer_len,
    input  logic              xfer_done,
    output logic              busy,
    output logic              done,
    output logic              error
);
    logic [ADDR_W-1:0] list_base, base_q;
    logic [WORD_W-1:0] link_q, size_q;
    logic start, start_list, stop, open, last;
    logic addr_ok, len_ok, ld_link, ld_base, ld_size;

    lldma_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .open_i(open), .ld_link_i(ld_link), .ld_base_i(ld_base), .ld_size_i(ld_size),
        .rd_data_i(rd_data),
        .list_base_o(list_base), .link_o(link_q), .base_o(base_q), .size_o(size_q),
        .start_o(start), .start_list_o(start_list), .stop_o(stop)
    );

    lldma_buf_check #(.ADDR_W(ADDR_W), .BLK_LG2(BLK_LG2)) u_chk (
        .base_i(base_q), .len_i(size_q), .last_i(last),
        .addr_ok_o(addr_ok), .len_ok_o(len_ok)
    );

    lldma_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .start_list_i(start_list), .stop_i(stop),
        .link_i(link_q), .list_base_i(list_base),
        .addr_ok_i(addr_ok), .len_ok_i(len_ok),
        .xfer_done_i(xfer_done), .rd_valid_i(rd_valid),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .xfer_req_o(xfer_req),
        .last_o(last), .open_o(open),
        .busy_o(busy), .done_o(done), .err_o(error),
        .ld_link_o(ld_link), .ld_base_o(ld_base), .ld_size_o(ld_size)
    );

    assign xfer_addr = base_q;
    assign xfer_len  = size_q;

    // R6
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done && !stop |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));

    // R6
    fetch_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> $past(xfer_done));

    // R7
    xfer_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_addr[1:0] == 2'b00));
endmodule

// File: tb/sim_lldma_engine.sv
`timescale 1ns/1ps
module sim_lldma_engine;
    localparam int ADDR_W  = 32;
    localparam int BLK_LG2 = 4;
    localparam logic [31:0] CONT = 32'h8000_0000;
    localparam logic [31:0] LDSZ = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              rd_req, xfer_req, busy, done, error;
    logic [ADDR_W-1:0] rd_addr, xfer_addr;
    logic              rd_valid = 1'b0;
    logic [31:0]       rd_data = '0;
    logic [31:0]       xfer_len;
    logic              xfer_done = 1'b0;

    lldma_engine #(.ADDR_W(ADDR_W), .BLK_LG2(BLK_LG2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .busy(busy), .done(done), .error(error)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] mem [64];
    logic [31:0] xa_log [8];
    logic [31:0] xl_log [8];
    logic [31:0] ra_log [16];
    int xn = 0;
    int rn = 0;
    int xfer_lat = 0;
    int wcnt = 0;
    int hold_bad = 0;
    logic [31:0] prev_a = '0;
    logic [31:0] prev_l = '0;

    // burst responder
    always @(negedge clk) begin
        if (xfer_done) begin
            xfer_done = 1'b0;
        end else if (xfer_req) begin
            if (wcnt > 0 && (xfer_addr !== prev_a || xfer_len !== prev_l)) hold_bad++;
            if (rd_req) hold_bad++;
            prev_a = xfer_addr;
            prev_l = xfer_len;
            if (wcnt >= xfer_lat) begin
                if (xn < 8) begin
                    xa_log[xn] = xfer_addr;
                    xl_log[xn] = xfer_len;
                end
                xn++;
                xfer_done = 1'b1;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    // descriptor memory responder
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
        end else if (rd_req) begin
            if (rn < 16) ra_log[rn] = rd_addr;
            rn++;
            rd_data  = mem[rd_addr[7:2]];
            rd_valid = 1'b1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_logs();
        xn = 0; rn = 0; hold_bad = 0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic wait_rest();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_xfer();
        for (int i = 0; i < 50 && !xfer_req; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "error", error, 0);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "xfer_req", xfer_req, 0);
    endtask

    task automatic t_single();
        clear_logs();
        cfg_wr(3'd2, CONT | LDSZ | 32'd12);
        cfg_wr(3'd3, 32'h1000);
        cfg_wr(3'd4, 32'h123);
        cfg_wr(3'd0, 32'd1);
        wait_rest();
        chk("R2", "single count", xn, 1);
        chk("R2", "single addr", xa_log[0], 32'h1000);
        chk("R2", "single len", xl_log[0], 32'h123);
        chk("R2", "no reads", rn, 0);
        chk("R2", "done", done, 1);
        chk("R2", "error", error, 0);
    endtask

    task automatic t_single_misaligned();
        clear_logs();
        cfg_wr(3'd3, 32'h1002);
        cfg_wr(3'd0, 32'd1);
        wait_rest();
        chk("R7", "single bad addr count", xn, 0);
        chk("R7", "single bad addr error", error, 1);
        chk("R7", "single bad addr done", done, 0);
        cfg_wr(3'd0, 32'd0);
        chk("R9", "stop clears error", error, 0);
    endtask

    task automatic t_list3();
        clear_logs();
        xfer_lat = 2;
        mem[19] = CONT | LDSZ | 32'd24; mem[20] = 32'h3000; mem[21] = 32'd32;
        mem[22] = 32'h0;                mem[23] = 32'h4004; mem[24] = 32'd7;
        cfg_wr(3'd1, 32'h40);
        cfg_wr(3'd2, CONT | LDSZ | 32'd12);
        cfg_wr(3'd3, 32'h2000);
        cfg_wr(3'd4, 32'd64);
        cfg_wr(3'd0, 32'd3);
        wait_rest();
        chk("R3", "list count", xn, 3);
        chk("R3", "buf0 addr", xa_log[0], 32'h2000);
        chk("R3", "buf0 len", xl_log[0], 32'd64);
        chk("R3", "buf1 addr", xa_log[1], 32'h3000);
        chk("R3", "buf1 len", xl_log[1], 32'd32);
        chk("R8", "last addr", xa_log[2], 32'h4004);
        chk("R8", "last odd len", xl_log[2], 32'd7);
        chk("R3", "read count", rn, 6);
        chk("R3", "read0", ra_log[0], 32'h4C);
        chk("R3", "read1", ra_log[1], 32'h50);
        chk("R3", "read2", ra_log[2], 32'h54);
        chk("R3", "read3", ra_log[3], 32'h58);
        chk("R3", "read5", ra_log[5], 32'h60);
        chk("R6", "req hold violations", hold_bad, 0);
        chk("R5", "done", done, 1);
        chk("R5", "busy", busy, 0);
        xfer_lat = 0;
    endtask

    task automatic t_keep_size();
        clear_logs();
        xfer_lat = 6;
        mem[35] = 32'h0; mem[36] = 32'h200; mem[37] = 32'd5;
        cfg_wr(3'd1, 32'h80);
        cfg_wr(3'd2, CONT | 32'd12);
        cfg_wr(3'd3, 32'h100);
        cfg_wr(3'd4, 32'd48);
        cfg_wr(3'd0, 32'd3);
        wait_xfer();
        cfg_wr(3'd4, 32'h999);   // R11: ignored while busy
        cfg_wr(3'd1, 32'h0);     // R11: ignored while busy
        wait_rest();
        chk("R4", "count", xn, 2);
        chk("R4", "buf1 addr", xa_log[1], 32'h200);
        chk("R4", "buf1 reused len", xl_log[1], 32'd48);
        chk("R11", "busy write ignored len", xl_log[0], 32'd48);
        chk("R4", "size word skipped", rn, 2);
        chk("R11", "list base kept", ra_log[0], 32'h8C);
        chk("R6", "req hold violations", hold_bad, 0);
        chk("R5", "done", done, 1);
        xfer_lat = 0;
    endtask

    task automatic t_fetched_misaligned();
        clear_logs();
        mem[19] = 32'h0; mem[20] = 32'h3001; mem[21] = 32'd16;
        cfg_wr(3'd1, 32'h40);
        cfg_wr(3'd2, CONT | LDSZ | 32'd12);
        cfg_wr(3'd3, 32'h2000);
        cfg_wr(3'd4, 32'd32);
        cfg_wr(3'd0, 32'd3);
        wait_rest();
        chk("R7", "fetched bad addr count", xn, 1);
        chk("R7", "fetched bad addr error", error, 1);
        chk("R7", "busy", busy, 0);
    endtask

    task automatic t_bad_size();
        clear_logs();
        cfg_wr(3'd1, 32'h40);
        cfg_wr(3'd2, CONT | LDSZ | 32'd12);
        cfg_wr(3'd3, 32'h2000);
        cfg_wr(3'd4, 32'd20);
        cfg_wr(3'd0, 32'd3);
        wait_rest();
        chk("R8", "bad size count", xn, 0);
        chk("R8", "bad size error", error, 1);
    endtask

    task automatic t_abort();
        clear_logs();
        xfer_lat = 1000;
        cfg_wr(3'd3, 32'h1100);
        cfg_wr(3'd4, 32'd64);
        cfg_wr(3'd0, 32'd1);
        wait_xfer();
        chk("R9", "xfer_req before stop", xfer_req, 1);
        cfg_wr(3'd0, 32'd0);
        chk("R9", "xfer_req after stop", xfer_req, 0);
        chk("R9", "busy after stop", busy, 0);
        chk("R9", "done after stop", done, 0);
        chk("R9", "error after stop", error, 0);
        xfer_lat = 0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_single_misaligned();
        t_list3();
        t_keep_size();
        t_fetched_misaligned();
        t_bad_size();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule